// File: doc/BRIEF.md
# I2C Target with Byte Handshake

This block is an I2C target that runs from a system clock and oversamples the SCL and SDA lines, at roughly ten system clocks per bit (for example a 1 MHz system clock with a 100 kHz SCL). It recognises START and STOP conditions and collects the first byte after a START as a 7-bit address followed by a direction bit. It answers the address with an ACK only when the address exactly equals the `own_addr` input. The all-zero general-call address is never answered.

When the master writes, every received byte is handed to the user logic through a one-clock `rx_valid` strobe, with the byte on `rx_data`. The target drives the ACK for each byte.

When the master reads, the target raises a one-clock `tx_req` strobe and captures `tx_data` shortly afterwards. It then shifts that byte out MSB first. A master NACK ends the read.

The `busy` output marks the span from a START to the following STOP. The SDA pin is open drain. `sda_oe` high means "pull SDA low".

Top module: `i2c_target`

## Requirements
- R1: After reset, `busy`, `sda_oe`, `rx_valid` and `tx_req` are all 0.
- R2: `busy` goes to 1 after a START (SDA falling while SCL is high) and returns to 0 after a STOP (SDA rising while SCL is high).
- R3: After a START, the first byte is taken MSB first. Its first seven bits are the address and its eighth bit is the direction (1 = read, 0 = write). The target pulls SDA low in the ninth clock only if the address equals `own_addr`. On a mismatch it drives SDA at no time until the next START and raises no `rx_valid`.
- R4: The address 0000000 is never acknowledged, even when `own_addr` is 0000000.
- R5: In a write, each data byte is received MSB first and presented on `rx_data` with a `rx_valid` strobe. The target acknowledges it by pulling SDA low in the ninth clock.
- R6: In a read, the target raises `tx_req` for one clock. It captures `tx_data` on the second clock edge after `tx_req` rises, then sends that byte MSB first, pulling SDA low exactly for the 0 bits.
- R7: A master ACK after a read byte causes a new `tx_req` and a new byte. A master NACK makes the target release SDA: it raises no `tx_req` and drives nothing until the next START.
- R8: A repeated START inside a transaction returns the target to address reception, and the new direction bit takes effect.
- R9: `sda_oe` only turns on while SCL is low.
- R10: `rx_valid` and `tx_req` are single-clock pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| own_addr | input | 7 | Target address to respond to |
| busy | output | 1 | Transfer active on the bus (START until STOP) |
| rx_valid | output | 1 | One-clock strobe: written byte ready on rx_data |
| rx_data | output | 8 | Last byte written by the master |
| tx_req | output | 1 | One-clock strobe: supply next read byte on tx_data |
| tx_data | input | 8 | Byte to be sent in a read |

## Verification
A bit-banging master drives the bench. It issues writes with several data values, and reads in which the target sends bytes mixing 1 and 0 bits. This shows that the 0 bits are pulled low and the 1 bits are released.

Transactions to a wrong address and to the general-call address with `own_addr` at zero check that the address match is exact, not partial. A read that ends in a NACK followed by extra clocks shows the target really releases the line. A write followed by a repeated START into a read shows the direction is taken from the new address byte rather than kept from the old one.

// File: rtl/i2c_target.sv
module i2c_target (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe,
  input  logic [6:0] own_addr,
  output logic       busy,
  output logic       rx_valid,
  output logic [7:0] rx_data,
  output logic       tx_req,
  input  logic [7:0] tx_data
);

  typedef enum logic [2:0] {IDLE, ADDR, ADDR_ACK, WR, WR_ACK, RD, RD_ACK, RD_GO} st_t;

  st_t        st;
  logic [2:0] scl_p, sda_p;
  logic [7:0] sh;
  logic [3:0] cnt;
  logic       rw, ld;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_p <= 3'b111;
      sda_p <= 3'b111;
    end else begin
      scl_p <= {scl_p[1:0], scl_i};
      sda_p <= {sda_p[1:0], sda_i};
    end

  wire scl      = scl_p[1];
  wire sda      = sda_p[1];
  wire scl_rise = scl_p[1] & ~scl_p[2];
  wire scl_fall = ~scl_p[1] & scl_p[2];
  wire start_c  = scl_p[1] & scl_p[2] & sda_p[2] & ~sda_p[1];
  wire stop_c   = scl_p[1] & scl_p[2] & ~sda_p[2] & sda_p[1];
  wire hit      = (sh[7:1] == own_addr) && (|sh[7:1]);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st <= IDLE; sh <= '0; cnt <= '0; rw <= 1'b0; ld <= 1'b0;
      sda_oe <= 1'b0; busy <= 1'b0; rx_valid <= 1'b0; rx_data <= '0; tx_req <= 1'b0;
    end else begin
      rx_valid <= 1'b0;
      tx_req   <= 1'b0;
      ld       <= tx_req;
      if (ld) sh <= tx_data;
      if (start_c) begin
        busy <= 1'b1; st <= ADDR; cnt <= '0; sda_oe <= 1'b0;
      end else if (stop_c) begin
        busy <= 1'b0; st <= IDLE; sda_oe <= 1'b0;
      end else begin
        case (st)
          ADDR, WR:
            if (scl_rise) begin
              sh  <= {sh[6:0], sda};
              cnt <= cnt + 4'd1;
            end else if (scl_fall && cnt == 4'd8) begin
              if (st == ADDR) begin
                if (hit) begin
                  sda_oe <= 1'b1; rw <= sh[0]; tx_req <= sh[0]; st <= ADDR_ACK;
                end else st <= IDLE;
              end else begin
                rx_data <= sh; rx_valid <= 1'b1; sda_oe <= 1'b1; st <= WR_ACK;
              end
            end
          ADDR_ACK:
            if (scl_fall) begin
              cnt <= '0;
              if (rw) begin sda_oe <= ~sh[7]; st <= RD; end
              else    begin sda_oe <= 1'b0;   st <= WR; end
            end
          WR_ACK:
            if (scl_fall) begin sda_oe <= 1'b0; cnt <= '0; st <= WR; end
          RD:
            if (scl_fall) begin
              if (cnt == 4'd7) begin
                sda_oe <= 1'b0; st <= RD_ACK;
              end else begin
                sh <= {sh[6:0], 1'b0}; sda_oe <= ~sh[6]; cnt <= cnt + 4'd1;
              end
            end
          RD_ACK:
            if (scl_rise) begin
              if (sda) st <= IDLE;
              else begin tx_req <= 1'b1; st <= RD_GO; end
            end
          RD_GO:
            if (scl_fall) begin sda_oe <= ~sh[7]; cnt <= '0; st <= RD; end
          default: ;
        endcase
      end
    end

  // R9
  oe_on_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl);
  // R3
  oe_needs_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sda_oe |-> busy);
  // R10
  rx_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);
  // R10
  tx_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_req |=> !tx_req);
  // R2
  stop_clears_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_c |=> !busy);

endmodule

// File: tb/i2c_target_bench.sv
module i2c_target_bench;
  localparam int CLK_PERIOD = 10;
  localparam int Q = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic m_scl = 1'b1, m_sda = 1'b1;
  logic [6:0] own_addr = 7'h2D;
  logic [7:0] tx_data = 8'h00;
  logic sda_oe, busy, rx_valid, tx_req;
  logic [7:0] rx_data;
  wire sda_line = m_sda & ~sda_oe;

  int n_tests = 0, n_fail = 0, n_rx = 0, n_req = 0;
  bit oe_seen = 0, prev_rx = 0, prev_req = 0, prev_oe = 0;
  logic [7:0] exp_rx[$];
  logic [7:0] tx_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_target u_i2c_target (
    .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_line), .sda_oe(sda_oe),
    .own_addr(own_addr), .busy(busy), .rx_valid(rx_valid), .rx_data(rx_data),
    .tx_req(tx_req), .tx_data(tx_data));

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n) begin
      if (sda_oe) oe_seen = 1;
      if (sda_oe && !prev_oe) check(!m_scl, "R9 oe rose with SCL high", m_scl, 0);
      if (rx_valid) begin
        n_rx++;
        check(!prev_rx, "R10 rx_valid width", 2, 1);
        if (exp_rx.size() == 0) check(0, "R5 unexpected byte", rx_data, 0);
        else begin
          logic [7:0] e;
          e = exp_rx.pop_front();
          check(rx_data == e, "R5 rx_data", rx_data, e);
        end
      end
      if (tx_req) begin
        n_req++;
        check(!prev_req, "R10 tx_req width", 2, 1);
        tx_data <= (tx_q.size() != 0) ? tx_q.pop_front() : 8'hEE;
      end
      prev_rx = rx_valid; prev_req = tx_req; prev_oe = sda_oe;
    end
  end

  task automatic wq(); repeat (Q) @(negedge clk); endtask

  task automatic bit_io(input logic b, output logic r);
    m_sda = b; wq(); m_scl = 1'b1; wq(); r = sda_line; wq(); m_scl = 1'b0; wq();
  endtask

  task automatic do_start();  m_sda = 1; m_scl = 1; wq(); m_sda = 0; wq(); m_scl = 0; wq(); endtask
  task automatic do_rstart(); m_sda = 1; wq(); m_scl = 1; wq(); m_sda = 0; wq(); m_scl = 0; wq(); endtask
  task automatic do_stop();   m_sda = 0; wq(); m_scl = 1; wq(); m_sda = 1; wq(); endtask

  task automatic send_byte(input logic [7:0] b, output logic nack);
    logic r;
    for (int i = 7; i >= 0; i--) bit_io(b[i], r);
    bit_io(1'b1, nack);
  endtask

  task automatic recv_byte(input logic mnack, output logic [7:0] v);
    logic r;
    for (int i = 7; i >= 0; i--) begin bit_io(1'b1, r); v[i] = r; end
    bit_io(mnack, r);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic nk;
    logic [7:0] v;
    int base;
    repeat (3) @(negedge clk);
    check(!busy && !sda_oe && !rx_valid && !tx_req, "R1 reset outputs",
          {busy, sda_oe, rx_valid, tx_req}, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // write two bytes
    do_start();
    check(busy, "R2 busy after START", busy, 1);
    send_byte({7'h2D, 1'b0}, nk);
    check(nk == 0, "R3 address ACK", nk, 0);
    exp_rx.push_back(8'hA5); send_byte(8'hA5, nk);
    check(nk == 0, "R5 data ACK", nk, 0);
    exp_rx.push_back(8'h3C); send_byte(8'h3C, nk);
    check(nk == 0, "R5 data ACK", nk, 0);
    do_stop(); wq();
    check(!busy, "R2 busy after STOP", busy, 0);
    check(n_rx == 2, "R5 byte count", n_rx, 2);

    // wrong address (one bit away)
    oe_seen = 0; base = n_rx;
    do_start();
    send_byte({7'h2C, 1'b0}, nk);
    check(nk == 1, "R3 mismatch no ACK", nk, 1);
    send_byte(8'h00, nk);
    check(nk == 1 && !oe_seen, "R3 mismatch stays silent", oe_seen, 0);
    check(n_rx == base, "R3 mismatch no rx_valid", n_rx, base);
    do_stop(); wq();

    // read two bytes, ACK then NACK
    tx_q.push_back(8'hC3); tx_q.push_back(8'h7E);
    base = n_req;
    do_start();
    send_byte({7'h2D, 1'b1}, nk);
    check(nk == 0, "R3 read address ACK", nk, 0);
    recv_byte(1'b0, v);
    check(v == 8'hC3, "R6 first read byte", v, 8'hC3);
    recv_byte(1'b1, v);
    check(v == 8'h7E, "R7 byte after master ACK", v, 8'h7E);
    oe_seen = 0;
    recv_byte(1'b1, v);
    check(v == 8'hFF && !oe_seen, "R7 released after NACK", v, 8'hFF);
    check(n_req == base + 2, "R7 no request after NACK", n_req, base + 2);
    do_stop(); wq();

    // write then repeated START into read
    tx_q.push_back(8'h5A);
    do_start();
    send_byte({7'h2D, 1'b0}, nk);
    exp_rx.push_back(8'h11); send_byte(8'h11, nk);
    check(nk == 0, "R8 write before restart", nk, 0);
    do_rstart();
    check(busy, "R8 busy across restart", busy, 1);
    send_byte({7'h2D, 1'b1}, nk);
    check(nk == 0, "R8 address ACK after restart", nk, 0);
    recv_byte(1'b1, v);
    check(v == 8'h5A, "R8 read after restart", v, 8'h5A);
    do_stop(); wq();

    // general call with own_addr = 0
    own_addr = 7'h00; oe_seen = 0; base = n_rx;
    do_start();
    send_byte(8'h00, nk);
    check(nk == 1 && !oe_seen, "R4 general call ignored", nk, 1);
    send_byte(8'h42, nk);
    check(n_rx == base, "R4 no byte delivered", n_rx, base);
    do_stop(); wq();
    own_addr = 7'h2D;

    check(exp_rx.size() == 0, "R5 scoreboard drained", exp_rx.size(), 0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule